// File: doc/BRIEF.md
# Fractional Q-Format Multiplier Unit

This block multiplies signed fractional operands held in 32-bit words. It covers full-word by full-word products (kept whole as a double word, or only its upper word), full-word by halfword products where the halfword is either half of operand B, halfword by halfword products, and a halfword by halfword product rounded to the upper halfword. A per-operation doubling control shifts the product left by one position, which aligns two Q-format fractions so that the binary point sits where a fraction expects it. The edge cases of that alignment are handled: the most-negative times most-negative input is flagged or saturated, depending on the form.

Operations enter on a valid/ready stream and results leave on a second valid/ready stream. With the default registered output, an accepted operation shows its result one cycle later. The result is held while the consumer stalls. Input is accepted only when the output register is empty or being drained in the same cycle, so back-pressure passes straight through to the producer. A four-bit flag register (overflow, sticky overflow, advance overflow, sticky advance overflow) is updated once per accepted operation and is read on plain status pins.

Top module: `qmul_unit`

## Requirements
- R1: An operation is accepted when `in_valid_i` and `in_ready_o` are both high, and `in_ready_o` is high whenever the output is empty or `out_ready_i` is high. The result appears on the output one clock after acceptance with `out_valid_o` high. While `out_valid_o` is high and `out_ready_i` is low, the output stays valid and its data does not change.
- R2: `op_i` selects the form. The codes are: 0 full×full 64-bit, 1 full×full upper word, 2 full×B-low-half 64-bit, 3 full×B-low-half 32-bit, 4 full×B-high-half 64-bit, 5 full×B-high-half 32-bit, 6 low×low halves, 7 high×high halves, 8 rounded low×low, 9 rounded high×high. A low halfword operand is bits 15:0 sign-extended. A high halfword operand is the word shifted arithmetically right by 16.
- R3: Code 0 returns the signed 64-bit product, doubled when `dbl_i` is 1, with the low word on `res_lo_o` and the high word on `res_hi_o`.
- R4: Code 1 returns product bits 63:32 when `dbl_i` is 0 and bits 62:31 when it is 1, on `res_lo_o`, with `res_hi_o` zero.
- R5: Codes 2 and 4 return the 64-bit product (doubled when `dbl_i` is 1) on both words. Codes 3 and 5 return product bits 47:16 when `dbl_i` is 0 and bits 46:15 when it is 1, with `res_hi_o` zero.
- R6: Codes 6 and 7 return the 32-bit product, doubled when `dbl_i` is 1. A doubled result of 0x80000000 is replaced by 0x7FFFFFFF. `res_hi_o` is zero.
- R7: Codes 8 and 9 form the halfword product, double it when `dbl_i` is 1, and add 0x8000. When doubling produced 0x80008000 it is replaced by 0x7FFF8000. Bits 15:0 are then cleared.
- R8: Flag bit 0 (V) is set on acceptance only for codes 0 to 5 with `dbl_i` at 1, and only when the result word (the high word for 64-bit forms) equals 0x80000000. Otherwise it is cleared. Flag bit 1 (SV) is ORed with the new V and never clears.
- R9: Flag bit 2 (AV) is bit 31 XOR bit 30 of the result word (the high word for 64-bit forms, the value before clearing for rounding forms). Flag bit 3 (SAV) is ORed with the new AV and never clears.
- R10: After reset, `out_valid_o` is low, `in_ready_o` is high and all four flags are zero.
- R11: The flags change only on a clock where an operation is accepted.
- R12: Codes 10 to 15 are reserved. They complete as a transaction with both result words zero and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Unit can take an operation |
| op_i | input | 4 | Operation form code |
| dbl_i | input | 1 | Double the product (fractional alignment) |
| a_i | input | 32 | Operand A word |
| b_i | input | 32 | Operand B word |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| res_lo_o | output | 32 | Result word, or low word of a 64-bit result |
| res_hi_o | output | 32 | High word of a 64-bit result, else zero |
| flags_o | output | 4 | {SAV, AV, SV, V} |

## Verification
An error in operand selection or in the slice picked from the doubled product shows as a wrong value on `res_lo_o` or `res_hi_o` one clock after the operation is accepted. Flag errors appear on `flags_o` on that same edge. A sticky bit that clears, or a flag that moves on a cycle with no acceptance, is visible at once and stays visible until the next acceptance. A fault in the output register shows during a stall, when the held result is replaced or `out_valid_o` drops before `out_ready_i` rises.

// File: rtl/qmul_pkg.sv
package qmul_pkg;

  typedef enum logic [3:0] {
    QOP_FULL64 = 4'd0,
    QOP_TOP32  = 4'd1,
    QOP_BLO64  = 4'd2,
    QOP_BLO32  = 4'd3,
    QOP_BHI64  = 4'd4,
    QOP_BHI32  = 4'd5,
    QOP_HLL    = 4'd6,
    QOP_HUU    = 4'd7,
    QOP_RLL    = 4'd8,
    QOP_RUU    = 4'd9
  } qop_e;

  typedef struct packed {
    logic sav;
    logic av;
    logic sv;
    logic v;
  } qflags_t;

  function automatic logic op_is_half(input logic [3:0] op);
    return (op == QOP_HLL) || (op == QOP_HUU) || (op == QOP_RLL) || (op == QOP_RUU);
  endfunction

  function automatic logic op_is_known(input logic [3:0] op);
    return op <= QOP_RUU;
  endfunction

endpackage

// File: rtl/qmul_operand_sel.sv
module qmul_operand_sel
  import qmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] opa_o,
  output logic [W-1:0] opb_o
);
  localparam int H = W / 2;

  logic [W-1:0] a_lo, a_hi, b_lo, b_hi;

  // low half: sign-extend bits H-1:0; high half: arithmetic shift by H
  assign a_lo = {{(W-H){a_i[H-1]}}, a_i[H-1:0]};
  assign b_lo = {{(W-H){b_i[H-1]}}, b_i[H-1:0]};
  assign a_hi = {{H{a_i[W-1]}}, a_i[W-1:H]};
  assign b_hi = {{H{b_i[W-1]}}, b_i[W-1:H]};

  always_comb begin
    opa_o = '0;
    opb_o = '0;
    case (op_i)
      QOP_FULL64, QOP_TOP32: begin opa_o = a_i;  opb_o = b_i;  end
      QOP_BLO64, QOP_BLO32:  begin opa_o = a_i;  opb_o = b_lo; end
      QOP_BHI64, QOP_BHI32:  begin opa_o = a_i;  opb_o = b_hi; end
      QOP_HLL, QOP_RLL:      begin opa_o = a_lo; opb_o = b_lo; end
      QOP_HUU, QOP_RUU:      begin opa_o = a_hi; opb_o = b_hi; end
      default:               begin opa_o = '0;   opb_o = '0;   end
    endcase
  end

endmodule

// File: rtl/qmul_core.sv
module qmul_core
  import qmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic         dbl_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] res_lo_o,
  output logic [W-1:0] res_hi_o,
  output logic         v_o,
  output logic         av_o
);
  localparam int H = W / 2;
  localparam int P = 2 * W;
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = ~MIN_NEG;
  localparam logic [W-1:0] HALF_LSB = W'(1) << (H-1);
  localparam logic [W-1:0] UP_MASK = {{(W-H){1'b1}}, {H{1'b0}}};
  localparam logic [W-1:0] RND_FIX = (MAX_POS & UP_MASK) | HALF_LSB;

  logic [P-1:0] prod, sh;
  logic [W-1:0] chk, half_p, rnd_p;

  // Lower 2W bits of the unsigned product of sign-extended operands
  // equal the signed product.
  assign prod = {{W{opa_i[W-1]}}, opa_i} * {{W{opb_i[W-1]}}, opb_i};
  assign sh   = dbl_i ? (prod << 1) : prod;

  assign half_p = sh[W-1:0];
  assign rnd_p  = sh[W-1:0] + HALF_LSB;

  always_comb begin
    res_lo_o = '0;
    res_hi_o = '0;
    chk      = '0;
    v_o      = 1'b0;
    case (op_i)
      QOP_FULL64, QOP_BLO64, QOP_BHI64: begin
        res_lo_o = sh[W-1:0];
        res_hi_o = sh[P-1:W];
        chk      = sh[P-1:W];
        v_o      = dbl_i && (sh[P-1:W] == MIN_NEG);
      end
      QOP_TOP32: begin
        res_lo_o = sh[P-1:W];
        chk      = sh[P-1:W];
        v_o      = dbl_i && (sh[P-1:W] == MIN_NEG);
      end
      QOP_BLO32, QOP_BHI32: begin
        res_lo_o = sh[W+H-1:H];
        chk      = sh[W+H-1:H];
        v_o      = dbl_i && (sh[W+H-1:H] == MIN_NEG);
      end
      QOP_HLL, QOP_HUU: begin
        chk      = (dbl_i && half_p == MIN_NEG) ? MAX_POS : half_p;
        res_lo_o = chk;
      end
      QOP_RLL, QOP_RUU: begin
        chk      = (dbl_i && rnd_p == (MIN_NEG | HALF_LSB)) ? RND_FIX : rnd_p;
        res_lo_o = chk & UP_MASK;
      end
      default: begin
        res_lo_o = '0;
      end
    endcase
  end

  assign av_o = chk[W-1] ^ chk[W-2];

endmodule

// File: rtl/qmul_flags.sv
module qmul_flags
  import qmul_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    upd_i,
  input  logic    v_i,
  input  logic    av_i,
  output qflags_t flags_o
);
  qflags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (upd_i) begin
      q.v   <= v_i;
      q.sv  <= q.sv | v_i;
      q.av  <= av_i;
      q.sav <= q.sav | av_i;
    end
  end

  assign flags_o = q;

  assert_flags_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_o));
  assert_sv_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.sv |=> flags_o.sv);
  assert_sv_covers_v_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.v |-> flags_o.sv);
  assert_sav_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.sav |=> flags_o.sav);
  assert_sav_covers_av_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.av |-> flags_o.sav);

endmodule

// File: rtl/qmul_unit.sv
module qmul_unit
  import qmul_pkg::*;
#(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [3:0]   op_i,
  input  logic         dbl_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] res_lo_o,
  output logic [W-1:0] res_hi_o,
  output logic [3:0]   flags_o
);
  logic [W-1:0] opa, opb, c_lo, c_hi;
  logic         c_v, c_av, accept;
  qflags_t      flg;

  qmul_operand_sel #(.W(W)) u_sel (
    .op_i (op_i), .a_i (a_i), .b_i (b_i), .opa_o (opa), .opb_o (opb)
  );

  qmul_core #(.W(W)) u_core (
    .op_i (op_i), .dbl_i (dbl_i), .opa_i (opa), .opb_i (opb),
    .res_lo_o (c_lo), .res_hi_o (c_hi), .v_o (c_v), .av_o (c_av)
  );

  qmul_flags u_flags (
    .clk_i (clk_i), .rst_ni (rst_ni), .upd_i (accept && op_is_known(op_i)),
    .v_i (c_v), .av_i (c_av), .flags_o (flg)
  );

  assign accept  = in_valid_i && in_ready_o;
  assign flags_o = flg;

  generate
    if (OUT_REG) begin : g_reg
      logic         vld_q;
      logic [W-1:0] lo_q, hi_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q <= 1'b0;
          lo_q  <= '0;
          hi_q  <= '0;
        end else begin
          if (accept) begin
            vld_q <= 1'b1;
            lo_q  <= c_lo;
            hi_q  <= c_hi;
          end else if (out_ready_i) begin
            vld_q <= 1'b0;
          end
        end
      end

      assign in_ready_o  = !vld_q || out_ready_i;
      assign out_valid_o = vld_q;
      assign res_lo_o    = lo_q;
      assign res_hi_o    = hi_q;

      assert_stall_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_lo_o) && $stable(res_hi_o));
      assert_accept_shows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> out_valid_o);
    end else begin : g_comb
      assign in_ready_o  = out_ready_i;
      assign out_valid_o = in_valid_i;
      assign res_lo_o    = c_lo;
      assign res_hi_o    = c_hi;
    end
  endgenerate

  assert_no_v_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && op_is_half(op_i) |=> !flags_o[0]);
  assert_v_clear_undoubled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !dbl_i && op_is_known(op_i) |=> !flags_o[0]);
  assert_reserved_keeps_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !op_is_known(op_i) |=> $stable(flags_o));

endmodule

// File: tb/qmul_unit_test.sv
`timescale 1ns/1ps
module qmul_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1, dbl = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        in_ready, out_valid;
  logic [31:0] res_lo, res_hi;
  logic [3:0]  flags;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  qmul_unit uut (
    .clk_i (clk), .rst_ni (rst_n), .in_valid_i (in_valid), .in_ready_o (in_ready),
    .op_i (op), .dbl_i (dbl), .a_i (a), .b_i (b), .out_valid_o (out_valid),
    .out_ready_i (out_ready), .res_lo_o (res_lo), .res_hi_o (res_hi), .flags_o (flags)
  );

  // {op, dbl, a, b, exp_lo, exp_hi, exp_v, exp_av}
  localparam int NV = 20;
  localparam logic [134:0] VEC [NV] = '{
    {4'd0, 1'b0, 32'h00010000, 32'h00010000, 32'h00000000, 32'h00000001, 1'b0, 1'b0},
    {4'd0, 1'b1, 32'h40000000, 32'h40000000, 32'h00000000, 32'h20000000, 1'b0, 1'b0},
    {4'd0, 1'b1, 32'h80000000, 32'h80000000, 32'h00000000, 32'h80000000, 1'b1, 1'b1},
    {4'd1, 1'b0, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0},
    {4'd1, 1'b1, 32'h40000000, 32'h40000000, 32'h20000000, 32'h00000000, 1'b0, 1'b0},
    {4'd1, 1'b1, 32'h80000000, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1},
    {4'd2, 1'b0, 32'h00000003, 32'hABCDFFFE, 32'hFFFFFFFA, 32'hFFFFFFFF, 1'b0, 1'b0},
    {4'd4, 1'b1, 32'h00000003, 32'h00021234, 32'h0000000C, 32'h00000000, 1'b0, 1'b0},
    {4'd3, 1'b0, 32'h00010000, 32'h11114000, 32'h00004000, 32'h00000000, 1'b0, 1'b0},
    {4'd5, 1'b1, 32'h80000000, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1},
    {4'd3, 1'b1, 32'h40000000, 32'h00004000, 32'h20000000, 32'h00000000, 1'b0, 1'b0},
    {4'd6, 1'b0, 32'h1234FFFF, 32'h56780005, 32'hFFFFFFFB, 32'h00000000, 1'b0, 1'b0},
    {4'd6, 1'b1, 32'h00008000, 32'h00008000, 32'h7FFFFFFF, 32'h00000000, 1'b0, 1'b1},
    {4'd7, 1'b1, 32'h40000000, 32'h20001234, 32'h10000000, 32'h00000000, 1'b0, 1'b0},
    {4'd7, 1'b0, 32'hC0000000, 32'h40000000, 32'hF0000000, 32'h00000000, 1'b0, 1'b0},
    {4'd8, 1'b0, 32'h00004000, 32'h00004000, 32'h10000000, 32'h00000000, 1'b0, 1'b0},
    {4'd8, 1'b1, 32'h00008000, 32'h00008000, 32'h7FFF0000, 32'h00000000, 1'b0, 1'b1},
    {4'd9, 1'b1, 32'h00010000, 32'h00030000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    {4'd9, 1'b0, 32'h01000000, 32'h01800000, 32'h00020000, 32'h00000000, 1'b0, 1'b0},
    {4'd1, 1'b0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000, 1'b0, 1'b1}
  };

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2, 4'd3, 4'd4, 4'd5: return "R2 R5";
      4'd6, 4'd7: return "R2 R6";
      default: return "R2 R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, accepted at next posedge, sample at following negedge.
  task automatic issue(input logic [3:0] o, input logic n,
                       input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op = o; dbl = n; a = x; b = y; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 4000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", {31'd0, in_ready}, 32'd1);
    check(flags == 4'h0, "R10", "flags during reset", {28'd0, flags}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags == 4'h0 && !out_valid, "R10", "state after release", {28'd0, flags}, 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [134:0] e;
      e = VEC[i];
      issue(e[134:131], e[130], e[129:98], e[97:66]);
      check(out_valid, "R1", "out_valid one cycle after accept", {31'd0, out_valid}, 32'd1);
      check(res_lo == e[65:34], req_of(e[134:131]), $sformatf("vec %0d res_lo", i), res_lo, e[65:34]);
      check(res_hi == e[33:2], req_of(e[134:131]), $sformatf("vec %0d res_hi", i), res_hi, e[33:2]);
      check(flags[0] == e[1], "R8", $sformatf("vec %0d V", i), {31'd0, flags[0]}, {31'd0, e[1]});
      check(flags[2] == e[0], "R9", $sformatf("vec %0d AV", i), {31'd0, flags[2]}, {31'd0, e[0]});
    end

    // R8 R9: sticky bits survive a clean operation
    issue(4'd6, 1'b0, 32'h00000001, 32'h00000001);
    check(flags == 4'b1010, "R8 R9", "sticky flags after clean op", {28'd0, flags}, 32'hA);
    issue(4'd6, 1'b1, 32'h00008000, 32'h00008000);
    check(flags == 4'b1110, "R9", "AV set by saturated halfword", {28'd0, flags}, 32'hE);

    // R12: reserved code
    issue(4'd12, 1'b1, 32'h80000000, 32'h80000000);
    check(out_valid && res_lo == 32'd0, "R12", "reserved res_lo", res_lo, 32'd0);
    check(res_hi == 32'd0, "R12", "reserved res_hi", res_hi, 32'd0);
    check(flags == 4'b1110, "R12", "reserved keeps flags", {28'd0, flags}, 32'hE);

    // R11: idle cycles leave flags alone, output drains
    repeat (3) @(negedge clk);
    check(flags == 4'b1110, "R11", "flags after idle", {28'd0, flags}, 32'hE);
    check(!out_valid, "R1", "output drained", {31'd0, out_valid}, 32'd0);

    // R1: back-pressure
    @(negedge clk);
    op = 4'd6; dbl = 1'b0; a = 32'd2; b = 32'd3; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check(out_valid && res_lo == 32'd6, "R1", "first result held", res_lo, 32'd6);
    check(!in_ready, "R1", "in_ready low in stall", {31'd0, in_ready}, 32'd0);
    a = 32'd4; b = 32'd4;
    @(negedge clk);
    check(out_valid && res_lo == 32'd6, "R1", "stalled result stable", res_lo, 32'd6);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && res_lo == 32'd16, "R1", "second result after release", res_lo, 32'd16);
    @(negedge clk);
    check(!out_valid, "R1", "valid drops when drained", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule